// File: doc/BRIEF.md
# Chainable Two-Channel 8-Bit Event Timer

This block holds two 8-bit up-counters, each with its own control, status, compare and count register, all reached through one small register port with a combinational read path. Each channel advances on one of three prescaled clock-enable inputs, which the surrounding chip supplies. A 3-bit source field in each control register picks the enable. A 2-bit clear field lets a channel reset itself on a compare match, on a high level at its external clear pin, or on either.

A special source code, 3'b100, links the channels. In channel 0 it joins the pair into one 16-bit counter, with channel 0 as the high byte. In channel 1 alone it makes channel 1 a counter of channel 0's compare-match events. Each channel keeps a sticky compare flag and a sticky overflow flag. In the 16-bit arrangement, the flag rules and the clear rules change so that the pair acts as one counter.

Top module: `cascade_timer_pair`

## Requirements
- R1: After reset both control registers read 0x00, both status registers read 0x00, both compare registers read 0xFF and both counters read 0x00.
- R2: Source field (control bits [2:0]): 3'b000 and 3'b101 to 3'b111 stop the channel. 3'b001, 3'b010 and 3'b011 add one for each cycle in which tickEn[0], tickEn[1] or tickEn[2] is high.
- R3: The overflow flag (status bit 1) is set when an increment takes the channel's 8-bit counter from 0xFF to 0x00. A software write or a clear never sets it.
- R4: The compare flag (status bit 0) is set one cycle after the counter first becomes equal to the compare register. A match event is the cycle in which equality begins.
- R5: Flags stay set until software writes 0 to that bit. Writing 1 to a bit has no effect. A flag event in the same cycle as the clearing write leaves the flag set.
- R6: Clear field (control bits [4:3]): bit 3 clears on a match event and bit 4 clears while the channel's extClr pin is high. A clear takes priority over a count write and over an increment, and the counter reads 0x00 in the next cycle.
- R7: When channel 0's source is 3'b100, the pair is one 16-bit counter with channel 0 as the upper byte. Channel 1 advances on its own source enable, and each wrap of channel 1 from 0xFF to 0x00 adds one to channel 0. Each byte sets its own overflow flag on its own wrap.
- R8: In 16-bit mode, channel 0's compare flag is set only on a match of all 16 bits against {compare 0, compare 1}. Channel 1's compare flag is set on a low-byte match.
- R9: In 16-bit mode, channel 0's clear field clears both bytes, either on a 16-bit match event or on a high level at extClr[0]. Match clear still works when pin clear is also selected. Channel 1's clear field and extClr[1] have no effect.
- R10: When channel 1's source is 3'b100 and channel 0's is not, channel 1 adds one in the cycle after each match event of channel 0.
- R11: Register address: bit 2 picks the channel and bits [1:0] pick control (0), status (1), compare (2) or count (3). A write to count loads the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 3 | Register address: channel in bit 2, register in bits 1:0 |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the addressed register (combinational) |
| tickEn | input | 3 | Prescaled clock-enable inputs |
| extClr | input | 2 | External counter clear pins, one per channel, active high |

## Verification
A wrong count or a missed increment shows on the count register in the cycle after the enabling edge. A wrong carry or a misrouted clear shows in the other byte one cycle later. The sweeps over start values and burst lengths would expose these. A wrong equality tracker shows up in two ways: a compare flag that is set one cycle early or late, or an event counter in channel 1 that drifts from the number of channel 0 periods. The bench computes both quantities arithmetically.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

  localparam int NCH    = 2;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 3;
  localparam int CLR_W  = 2;

  // Source field codes; ticks occupy codes 1 .. NUM_TICK
  localparam logic [SEL_W-1:0] SEL_STOP  = 3'b000;
  localparam logic [SEL_W-1:0] SEL_CHAIN = 3'b100;

  // Clear field bit positions
  localparam int CLR_ON_MATCH = 0;
  localparam int CLR_ON_PIN   = 1;

  // Status bit positions
  localparam int STAT_CMP = 0;
  localparam int STAT_OVF = 1;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_CMP  = 2'd2,
    REG_CNT  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic clr;
    logic ld;
    logic inc;
  } chStrobe_t;

endpackage

// File: rtl/tmr_pair_dpath.sv
module tmr_pair_dpath
  import tmr_pair_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  chStrobe_t [NCH-1:0]            str,
  input  logic      [CNT_W-1:0]          ldData,
  input  logic      [NCH-1:0][CNT_W-1:0] cmpVal,
  output logic      [NCH-1:0][CNT_W-1:0] cnt,
  output logic      [NCH-1:0]            matchEv8,
  output logic                           matchEv16
);

  logic [NCH-1:0] eq8;
  logic [NCH-1:0] eqPrev8;
  logic           eq16;
  logic           eqPrev16;

  // Counter update: clear beats load, load beats increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (str[ch].clr)      cnt[ch] <= '0;
        else if (str[ch].ld)  cnt[ch] <= ldData;
        else if (str[ch].inc) cnt[ch] <= cnt[ch] + CNT_W'(1);
      end
    end
  end

  // Equality trackers: an event is the first cycle of equality
  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      eq8[ch] = (cnt[ch] == cmpVal[ch]);
    end
    eq16 = &eq8;
  end

  assign matchEv8  = eq8 & ~eqPrev8;
  assign matchEv16 = eq16 & ~eqPrev16;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eqPrev8  <= '0;
      eqPrev16 <= 1'b0;
    end else begin
      eqPrev8  <= eq8;
      eqPrev16 <= eq16;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    // R6: a clear strobe leaves the counter at zero
    a_r6_clear_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
      str[ch].clr |=> (cnt[ch] == '0));
    // R2: with no strobe the counter holds
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
      (!str[ch].clr && !str[ch].ld && !str[ch].inc) |=> $stable(cnt[ch]));
    // R11: a load without clear takes the write data
    a_r11_load_takes_value: assert property (@(posedge clk) disable iff (!rstN)
      (str[ch].ld && !str[ch].clr) |=> (cnt[ch] == $past(ldData)));
  end

endmodule

// File: rtl/tmr_pair_ctrl.sv
module tmr_pair_ctrl
  import tmr_pair_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int NUM_TICK = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic      [ADDR_W-1:0]         regAddr,
  input  logic                           regWrEn,
  input  logic      [CNT_W-1:0]          regWrData,
  output logic      [CNT_W-1:0]          regRdData,
  input  logic      [NUM_TICK-1:0]       tickEn,
  input  logic      [NCH-1:0]            extClr,
  input  logic      [NCH-1:0][CNT_W-1:0] cnt,
  input  logic      [NCH-1:0]            matchEv8,
  input  logic                           matchEv16,
  output chStrobe_t [NCH-1:0]            str,
  output logic      [CNT_W-1:0]          ldData,
  output logic      [NCH-1:0][CNT_W-1:0] cmpVal
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int CTRL_W = SEL_W + CLR_W;

  // Register state
  logic [NCH-1:0][SEL_W-1:0] selReg;
  logic [NCH-1:0][CLR_W-1:0] clrReg;
  logic [NCH-1:0][CNT_W-1:0] cmpReg;
  logic [NCH-1:0]            cmpFlag;
  logic [NCH-1:0]            ovfFlag;

  // Address decode
  logic           addrCh;
  regSel_e        addrReg;
  logic [NCH-1:0] hitCtrl, hitStat, hitCmp, hitCnt;

  assign addrCh  = regAddr[ADDR_W-1];
  assign addrReg = regSel_e'(regAddr[1:0]);

  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      hitCtrl[ch] = regWrEn && (addrCh == 1'(ch)) && (addrReg == REG_CTRL);
      hitStat[ch] = regWrEn && (addrCh == 1'(ch)) && (addrReg == REG_STAT);
      hitCmp[ch]  = regWrEn && (addrCh == 1'(ch)) && (addrReg == REG_CMP);
      hitCnt[ch]  = regWrEn && (addrCh == 1'(ch)) && (addrReg == REG_CNT);
    end
  end

  // Mode decode: channel 0 chaining wins over channel 1 chaining
  logic chain16;
  logic evCount;
  assign chain16 = (selReg[0] == SEL_CHAIN);
  assign evCount = (selReg[1] == SEL_CHAIN) && !chain16;

  // Tick source per channel
  logic [NCH-1:0] srcTick;
  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      srcTick[ch] = 1'b0;
      for (int k = 0; k < NUM_TICK; k++) begin
        if (selReg[ch] == SEL_W'(k + 1)) srcTick[ch] = tickEn[k];
      end
    end
  end

  // Clear, increment, wrap
  logic [NCH-1:0] clrCmd, incReq, effInc, wrap, cmpSet;
  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      clrCmd[ch] = (clrReg[ch][CLR_ON_MATCH] & matchEv8[ch])
                 | (clrReg[ch][CLR_ON_PIN]   & extClr[ch]);
    end
    if (chain16) begin
      clrCmd[0] = (clrReg[0][CLR_ON_MATCH] & matchEv16)
                | (clrReg[0][CLR_ON_PIN]   & extClr[0]);
      clrCmd[1] = clrCmd[0];
    end

    incReq[1] = evCount ? matchEv8[0] : srcTick[1];
    effInc[1] = incReq[1] & ~clrCmd[1] & ~hitCnt[1];
    wrap[1]   = effInc[1] & (cnt[1] == CNT_MAX);

    incReq[0] = chain16 ? wrap[1] : srcTick[0];
    effInc[0] = incReq[0] & ~clrCmd[0] & ~hitCnt[0];
    wrap[0]   = effInc[0] & (cnt[0] == CNT_MAX);

    cmpSet[0] = chain16 ? matchEv16 : matchEv8[0];
    cmpSet[1] = matchEv8[1];
  end

  // Strobes to the datapath
  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      str[ch].clr = clrCmd[ch];
      str[ch].ld  = hitCnt[ch];
      str[ch].inc = effInc[ch];
    end
  end

  assign ldData = regWrData;
  assign cmpVal = cmpReg;

  // Register writes and sticky flags (set wins over clearing write)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg  <= '0;
      clrReg  <= '0;
      cmpReg  <= '1;
      cmpFlag <= '0;
      ovfFlag <= '0;
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (hitCtrl[ch]) begin
          selReg[ch] <= regWrData[SEL_W-1:0];
          clrReg[ch] <= regWrData[SEL_W +: CLR_W];
        end
        if (hitCmp[ch]) cmpReg[ch] <= regWrData;
        cmpFlag[ch] <= cmpSet[ch]
                     | (cmpFlag[ch] & ~(hitStat[ch] & ~regWrData[STAT_CMP]));
        ovfFlag[ch] <= wrap[ch]
                     | (ovfFlag[ch] & ~(hitStat[ch] & ~regWrData[STAT_OVF]));
      end
    end
  end

  // Read mux
  always_comb begin
    regRdData = '0;
    case (addrReg)
      REG_CTRL: regRdData[CTRL_W-1:0] = {clrReg[addrCh], selReg[addrCh]};
      REG_STAT: begin
        regRdData[STAT_CMP] = cmpFlag[addrCh];
        regRdData[STAT_OVF] = ovfFlag[addrCh];
      end
      REG_CMP:  regRdData = cmpReg[addrCh];
      REG_CNT:  regRdData = cnt[addrCh];
      default:  regRdData = '0;
    endcase
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    // R3: overflow flag rises only after the counter stood at its maximum
    a_r3_ovf_only_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ovfFlag[ch]) |-> ($past(cnt[ch]) == CNT_MAX));
    // R5: a flag without a clearing write stays set
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (cmpFlag[ch] && !(hitStat[ch] && !regWrData[STAT_CMP])) |=> cmpFlag[ch]);
  end

  // R9: a 16-bit clear empties both bytes
  a_r9_both_bytes_clear: assert property (@(posedge clk) disable iff (!rstN)
    (chain16 && clrCmd[0]) |=> (cnt[0] == '0 && cnt[1] == '0));

  // R10: in event-count mode channel 1 follows channel 0 match events
  a_r10_counts_events: assert property (@(posedge clk) disable iff (!rstN)
    (evCount && !clrCmd[1] && !hitCnt[1])
      |=> (cnt[1] == $past(cnt[1]) + CNT_W'($past(matchEv8[0]))));

endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
  import tmr_pair_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int NUM_TICK = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [CNT_W-1:0]    regWrData,
  output logic [CNT_W-1:0]    regRdData,
  input  logic [NUM_TICK-1:0] tickEn,
  input  logic [NCH-1:0]      extClr
);

  chStrobe_t [NCH-1:0]            str;
  logic      [CNT_W-1:0]          ldData;
  logic      [NCH-1:0][CNT_W-1:0] cmpVal;
  logic      [NCH-1:0][CNT_W-1:0] cnt;
  logic      [NCH-1:0]            matchEv8;
  logic                           matchEv16;

  tmr_pair_ctrl #(
    .CNT_W    (CNT_W),
    .NUM_TICK (NUM_TICK)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .tickEn    (tickEn),
    .extClr    (extClr),
    .cnt       (cnt),
    .matchEv8  (matchEv8),
    .matchEv16 (matchEv16),
    .str       (str),
    .ldData    (ldData),
    .cmpVal    (cmpVal)
  );

  tmr_pair_dpath #(
    .CNT_W (CNT_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .str       (str),
    .ldData    (ldData),
    .cmpVal    (cmpVal),
    .cnt       (cnt),
    .matchEv8  (matchEv8),
    .matchEv16 (matchEv16)
  );

endmodule

// File: tb/tb_cascade_timer_pair.sv
`timescale 1ns/1ps
module tb_cascade_timer_pair;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [2:0] tickEn = '0;
  logic [1:0] extClr = '0;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  cascade_timer_pair dut (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .tickEn    (tickEn),
    .extClr    (extClr)
  );

  always #2.5 clk = ~clk;

  // Addresses: {channel, register}
  localparam logic [2:0] CTRL0 = 3'd0, STAT0 = 3'd1, CMP0 = 3'd2, CNT0 = 3'd3;
  localparam logic [2:0] CTRL1 = 3'd4, STAT1 = 3'd5, CMP1 = 3'd6, CNT1 = 3'd7;

  function automatic logic [7:0] ctl(input logic [1:0] clrF, input logic [2:0] selF);
    return {3'b000, clrF, selF};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic chkReg(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic chkBit(input string tag, input logic [2:0] a, input int b, input logic exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, {7'b0, v[b]}, {7'b0, exp});
  endtask

  task automatic tick(input logic [2:0] mask, input int n);
    repeat (n) begin
      @(negedge clk);
      tickEn = mask;
    end
    @(negedge clk);
    tickEn = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    logic [15:0] starts [4];
    int          lens   [4];
    logic [7:0]  cmpList [3];
    logic [7:0]  hi, lo;
    starts = '{16'h12FE, 16'h00FF, 16'h7FF0, 16'hFFFE};
    lens   = '{1, 2, 3, 17};
    cmpList = '{8'h01, 8'h80, 8'hFF};

    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1: reset values, all eight registers (R11 map)
    chkReg("R1 ctrl0", CTRL0, 8'h00);
    chkReg("R1 stat0", STAT0, 8'h00);
    chkReg("R1 cmp0",  CMP0,  8'hFF);
    chkReg("R1 cnt0",  CNT0,  8'h00);
    chkReg("R1 ctrl1", CTRL1, 8'h00);
    chkReg("R1 stat1", STAT1, 8'h00);
    chkReg("R1 cmp1",  CMP1,  8'hFF);
    chkReg("R1 cnt1",  CNT1,  8'h00);

    // R2: every non-chaining source code against every tick input
    for (int s = 0; s < 8; s++) begin
      if (s == 4) continue;
      for (int j = 0; j < 3; j++) begin
        wr(CNT0, 8'h00);
        wr(CTRL0, ctl(2'b00, 3'(s)));
        tick(3'(1 << j), 5);
        chkReg($sformatf("R2 sel %0d tick %0d", s, j), CNT0, (s == j + 1) ? 8'd5 : 8'd0);
      end
    end
    wr(CTRL1, ctl(2'b00, 3'b011));
    wr(CNT1, 8'h00);
    tick(3'b111, 7);
    chkReg("R2 ch1 tick2 with all enables", CNT1, 8'd7);
    wr(CTRL1, 8'h00);
    wr(CNT1, 8'h00);

    // R3/R4: wrap and match flags on channel 0
    wr(CTRL0, ctl(2'b00, 3'b001));
    wr(STAT0, 8'h00);
    wr(CNT0, 8'hFD);
    tick(3'b001, 2);
    chkReg("R3 no ovf before wrap", STAT0, 8'h00);
    idle(1);
    chkReg("R4 cmp flag after reaching 0xFF", STAT0, 8'h01);
    tick(3'b001, 1);
    chkReg("R3 ovf on wrap", STAT0, 8'h03);
    chkReg("R3 counter wrapped", CNT0, 8'h00);
    wr(STAT0, 8'h00);
    wr(CNT0, 8'hFF);
    wr(CNT0, 8'h00);
    idle(2);
    chkBit("R3 write does not set ovf", STAT0, 1, 1'b0);

    // R5: selective clear, write 1 ignored
    wr(CNT0, 8'hFF);
    tick(3'b001, 1);
    idle(1);
    chkReg("R5 both flags set", STAT0, 8'h03);
    wr(STAT0, 8'h02);
    chkReg("R5 clear cmp only", STAT0, 8'h02);
    wr(STAT0, 8'h01);
    chkReg("R5 clear ovf only", STAT0, 8'h00);
    // R5: set in the same cycle as the clearing write
    wr(CNT0, 8'hFE);
    @(negedge clk);
    tickEn = 3'b001;
    @(negedge clk);
    tickEn = '0;
    regAddr = STAT0; regWrData = 8'h00; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    chkBit("R5 set wins over clear", STAT0, 0, 1'b1);

    // R6: clear on match
    wr(STAT0, 8'h00);
    wr(CMP0, 8'h05);
    wr(CNT0, 8'h00);
    wr(CTRL0, ctl(2'b01, 3'b001));
    tick(3'b001, 5);
    chkReg("R6 value at match", CNT0, 8'h05);
    idle(1);
    chkReg("R6 cleared after match", CNT0, 8'h00);
    chkBit("R4 cmp flag with clear", STAT0, 0, 1'b1);
    // R6: pin clear beats increment
    wr(CTRL0, ctl(2'b10, 3'b001));
    wr(CNT0, 8'h40);
    @(negedge clk);
    tickEn = 3'b001; extClr = 2'b01;
    @(negedge clk);
    tickEn = '0; extClr = 2'b00;
    chkReg("R6 pin clear beats increment", CNT0, 8'h00);
    // R6: pin clear beats write
    wr(CNT0, 8'h40);
    @(negedge clk);
    regAddr = CNT0; regWrData = 8'h33; regWrEn = 1'b1; extClr = 2'b01;
    @(negedge clk);
    regWrEn = 1'b0; extClr = 2'b00;
    chkReg("R6 pin clear beats write", CNT0, 8'h00);
    // R6: pin has no effect when not selected
    wr(CTRL0, ctl(2'b00, 3'b001));
    wr(CNT0, 8'h40);
    @(negedge clk);
    tickEn = 3'b001; extClr = 2'b01;
    @(negedge clk);
    tickEn = '0; extClr = 2'b00;
    chkReg("R6 pin ignored when unselected", CNT0, 8'h41);

    // R7: 16-bit counter sweep
    wr(CMP0, 8'hFF);
    wr(CMP1, 8'hFF);
    wr(CTRL0, ctl(2'b00, 3'b100));
    wr(CTRL1, ctl(2'b00, 3'b001));
    for (int si = 0; si < 4; si++) begin
      for (int li = 0; li < 4; li++) begin
        logic [15:0] expV;
        expV = starts[si] + 16'(lens[li]);
        wr(CNT0, starts[si][15:8]);
        wr(CNT1, starts[si][7:0]);
        tick(3'b001, lens[li]);
        rd(CNT0, hi);
        rd(CNT1, lo);
        check($sformatf("R7 hi %04h+%0d", starts[si], lens[li]), hi, expV[15:8]);
        check($sformatf("R7 lo %04h+%0d", starts[si], lens[li]), lo, expV[7:0]);
      end
    end
    wr(STAT0, 8'h00);
    wr(STAT1, 8'h00);
    wr(CNT0, 8'h12);
    wr(CNT1, 8'hFE);
    tick(3'b001, 3);
    chkBit("R7 low byte ovf", STAT1, 1, 1'b1);
    chkBit("R7 no high ovf on carry", STAT0, 1, 1'b0);
    chkReg("R7 carry into high", CNT0, 8'h13);
    wr(CNT0, 8'hFF);
    wr(CNT1, 8'hFF);
    tick(3'b001, 1);
    chkBit("R7 high ovf on 16-bit wrap", STAT0, 1, 1'b1);

    // R8: 16-bit vs low-byte compare flags
    wr(CMP0, 8'h02);
    wr(CMP1, 8'h05);
    wr(CNT0, 8'h01);
    wr(CNT1, 8'h00);
    wr(STAT0, 8'h00);
    wr(STAT1, 8'h00);
    tick(3'b001, 5);
    idle(1);
    chkBit("R8 low match sets ch1 flag", STAT1, 0, 1'b1);
    chkBit("R8 low match leaves ch0 flag", STAT0, 0, 1'b0);
    tick(3'b001, 256);
    idle(1);
    chkBit("R8 full match sets ch0 flag", STAT0, 0, 1'b1);

    // R9: clear rules in 16-bit mode
    wr(CTRL0, ctl(2'b11, 3'b100));
    wr(CTRL1, ctl(2'b11, 3'b001));
    wr(CNT1, 8'h00);
    wr(CNT0, 8'h01);
    tick(3'b001, 5);
    idle(2);
    chkReg("R9 ch1 match clear ignored lo", CNT1, 8'h05);
    chkReg("R9 ch1 match clear ignored hi", CNT0, 8'h01);
    wr(CNT1, 8'h00);
    wr(CNT0, 8'h02);
    tick(3'b001, 5);
    chkReg("R9 reached 16-bit match", CNT1, 8'h05);
    idle(1);
    chkReg("R9 match clear with pin selected lo", CNT1, 8'h00);
    chkReg("R9 match clear with pin selected hi", CNT0, 8'h00);
    wr(CNT1, 8'h30);
    wr(CNT0, 8'h07);
    @(negedge clk);
    extClr = 2'b10;
    @(negedge clk);
    extClr = 2'b00;
    chkReg("R9 ch1 pin ignored", CNT1, 8'h30);
    @(negedge clk);
    extClr = 2'b01;
    @(negedge clk);
    extClr = 2'b00;
    chkReg("R9 ch0 pin clears lo", CNT1, 8'h00);
    chkReg("R9 ch0 pin clears hi", CNT0, 8'h00);

    // R10: channel 1 counts channel 0 match events
    wr(CTRL0, ctl(2'b01, 3'b001));
    wr(CMP0, 8'h03);
    wr(CTRL1, ctl(2'b00, 3'b100));
    wr(CMP1, 8'hFF);
    wr(CNT0, 8'h00);
    wr(CNT1, 8'h00);
    tick(3'b001, 40);
    idle(2);
    chkReg("R10 events with clear on match", CNT1, 8'd10);
    chkReg("R10 ch0 ended on clear", CNT0, 8'h00);
    wr(CTRL0, ctl(2'b00, 3'b001));
    for (int ci = 0; ci < 3; ci++) begin
      int nEv;
      nEv = (300 - int'(cmpList[ci])) / 256 + 1;
      wr(CMP0, cmpList[ci]);
      wr(CNT0, 8'h00);
      wr(CNT1, 8'h00);
      tick(3'b001, 300);
      idle(2);
      chkReg($sformatf("R10 events cmp %02h", cmpList[ci]), CNT1, 8'(nEv));
      chkReg($sformatf("R10 free run cmp %02h", cmpList[ci]), CNT0, 8'(300 % 256));
    end

    finishRun();
  end

endmodule